// File: doc/BRIEF.md
# Address-Pattern Bank Switch Controller

This block sits on the low address lines of a memory bus and selects one of sixteen memory banks without any writable register. A host unlocks a new selection by performing sixteen consecutive read cycles whose low four address bits form a fixed, built-in pattern. The last five of those reads carry the bank choice on one address line. Each read cycle is recognised by the falling edge of an active-low chip-enable input, and the chip enable is resampled on a system clock so that both its edges become one-cycle strobes.

The first eleven steps of the pattern are compared on all four lines. The last five are compared only on the three lines that do not carry the bank code. A read of all ones restarts entry. Any mismatch or any write cycle during entry throws the partial sequence away and leaves the current selection in force. The new selection takes effect when the chip enable rises at the end of the sixteenth matching read. From then on the gated chip-enable output follows the input chip enable, or is held inactive when the code switched all banks off.

Top module: `bank_unlock`

## Requirements
- R1: While `pwrOk` is low the block is in reset: `bankSel` reads 0, `ceOutN` reads 1 and pattern entry is at step 0.
- R2: One sample is taken per read cycle, in the clock cycle where `ceInN` is first seen low with `wrN` high. Holding `ceInN` low for several clocks still yields exactly one sample. The sample nibble is {addrW, addrX, addrY, addrZ}, with addrW as bit 3.
- R3: Steps 0 to 10 must equal, on all four bits, the nibbles 5, A, 3, C, 6, 9, 1, 8, 4, 2, E (hex) in that step order. A difference in any bit, including addrW, aborts entry.
- R4: Steps 11 to 15 compare bits 2..0 only, against 2, 5, 1, 6, 4 in that step order. addrW is free in these steps.
- R5: A read sample of 1111 resets entry, so that the next read is step 0. It is never taken as a pattern step.
- R6: A mismatching read clears entry to step 0 and leaves `bankSel` and `ceOutN` behaviour unchanged.
- R7: A cycle whose falling `ceInN` comes with `wrN` low (a write) clears entry to step 0 and leaves the selection unchanged.
- R8: A fully matched sequence changes `bankSel` only in the clock cycle after `ceInN` rises at the end of step 15, and not earlier.
- R9: If addrW at step 11 is 0, the commit turns all banks off: `bankSel` reads 0 and `ceOutN` stays 1 whatever `ceInN` does.
- R10: If addrW at step 11 is 1, the commit selects the bank whose number is addrW at steps 12, 13, 14, 15, most significant bit first. `bankSel` shows that number in binary, bit 3 first.
- R11: While a bank is selected, `ceOutN` equals `ceInN` combinationally. With `ceInN` high, `ceOutN` is always high.
- R12: The selection holds across any number of later reads and writes until another complete sequence commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| pwrOk | input | 1 | Power-good level, low holds the block in reset (asynchronous assert) |
| ceInN | input | 1 | Active-low chip enable of the memory bus |
| wrN | input | 1 | Active-low write strobe; high marks a read cycle |
| addrW | input | 1 | Address line, sample bit 3, carries the bank code in steps 11 to 15 |
| addrX | input | 1 | Address line, sample bit 2 |
| addrY | input | 1 | Address line, sample bit 1 |
| addrZ | input | 1 | Address line, sample bit 0 |
| bankSel | output | 4 | Selected bank number, 0 when banks are off |
| ceOutN | output | 1 | Gated active-low chip enable toward the memory |

## Verification
A clean sequence whose code bits differ from the pattern's own addrW values shows that the last five steps ignore that line. The same sequence with addrW flipped at step 10 shows that the first eleven steps do not. Sequences broken by a wrong nibble, by a write, or by an all-ones read separate the abort paths from the restart path: after an abort the remaining steps must not unlock, while an all-ones restart followed by a full sequence must. A read held low for several clocks tells one sample per cycle from one sample per clock. Checking before and after the final rising chip enable pins down the commit moment. A disabling code and a run of arbitrary reads after a selection separate the gating of `ceOutN` from the stability of `bankSel`.

// File: rtl/bank_unlock_pkg.sv
package bank_unlock_pkg;

  localparam int NIB_W = 4;

  // Built-in unlock pattern, step s in bits [4*s +: 4], nibble {W,X,Y,Z}.
  // Steps 11..15 hold addrW as 0; that bit is masked during compare.
  localparam logic [63:0] DEFAULT_PATTERN = 64'h4615_2E24_8196_C3A5;

  typedef struct packed {
    logic clearCode;   // drop any partially collected bank code
    logic shiftCode;   // push the current addrW into the code register
    logic commit;      // load the collected code into the bank state
  } ctrlStrb_t;

endpackage

// File: rtl/bank_unlock_edge.sv
module bank_unlock_edge (
  input  logic clk,
  input  logic pwrOk,
  input  logic ceInN,
  output logic fallStb,
  output logic riseStb
);

  logic ceDly;

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) begin
      ceDly <= 1'b1;
    end else begin
      ceDly <= ceInN;
    end
  end

  assign fallStb = ceDly & ~ceInN;
  assign riseStb = ~ceDly & ceInN;

endmodule

// File: rtl/bank_unlock_ctrl.sv
module bank_unlock_ctrl
  import bank_unlock_pkg::*;
#(
  parameter int NUM_STEPS  = 16,
  parameter int CODE_STEPS = 5,
  localparam int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              pwrOk,
  input  logic              fallStb,
  input  logic              riseStb,
  input  logic              wrN,
  input  logic              stepMatch,
  input  logic              allOnes,
  output logic [STEP_W-1:0] stepIdx,
  output ctrlStrb_t         strb
);

  localparam logic [STEP_W-1:0] FIRST_CODE = STEP_W'(NUM_STEPS - CODE_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] stepNext;
  logic              armed;
  logic              armedNext;

  always_comb begin
    stepNext  = stepIdx;
    armedNext = armed;
    strb      = '0;
    if (fallStb) begin
      armedNext = 1'b0;
      if (!wrN || allOnes) begin
        stepNext       = '0;
        strb.clearCode = 1'b1;
      end else if (stepMatch) begin
        strb.shiftCode = (stepIdx >= FIRST_CODE);
        if (stepIdx == LAST_STEP) begin
          stepNext  = '0;
          armedNext = 1'b1;
        end else begin
          stepNext = stepIdx + 1'b1;
        end
      end else begin
        stepNext       = '0;
        strb.clearCode = 1'b1;
      end
    end else if (riseStb && armed) begin
      strb.commit = 1'b1;
      armedNext   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) begin
      stepIdx <= '0;
      armed   <= 1'b0;
    end else begin
      stepIdx <= stepNext;
      armed   <= armedNext;
    end
  end

endmodule

// File: rtl/bank_unlock_dp.sv
module bank_unlock_dp
  import bank_unlock_pkg::*;
#(
  parameter int          NUM_STEPS  = 16,
  parameter int          CODE_STEPS = 5,
  parameter logic [63:0] PATTERN    = DEFAULT_PATTERN,
  localparam int STEP_W = $clog2(NUM_STEPS),
  localparam int BANK_W = CODE_STEPS - 1
) (
  input  logic              clk,
  input  logic              pwrOk,
  input  logic [NIB_W-1:0]  addrNib,
  input  logic              ceInN,
  input  logic [STEP_W-1:0] stepIdx,
  input  ctrlStrb_t         strb,
  output logic              stepMatch,
  output logic              allOnes,
  output logic [BANK_W-1:0] bankSel,
  output logic              ceOutN
);

  localparam logic [STEP_W-1:0] FIRST_CODE = STEP_W'(NUM_STEPS - CODE_STEPS);
  localparam int                CODE_LINE  = NIB_W - 1;

  logic [NIB_W-1:0]      expNib;
  logic                  codeStep;
  logic [NIB_W-1:0]      lineOk;
  logic [CODE_STEPS-1:0] codeSh;
  logic                  bankOn;
  logic [BANK_W-1:0]     bankNum;

  assign expNib   = PATTERN[stepIdx*NIB_W +: NIB_W];
  assign codeStep = (stepIdx >= FIRST_CODE);
  assign allOnes  = &addrNib;

  // Per-line compare; the code line is free in the code-carrying steps.
  for (genvar i = 0; i < NIB_W; i++) begin : g_line
    if (i == CODE_LINE) begin : g_code
      assign lineOk[i] = codeStep | (addrNib[i] == expNib[i]);
    end else begin : g_fixed
      assign lineOk[i] = (addrNib[i] == expNib[i]);
    end
  end

  assign stepMatch = &lineOk;

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) begin
      codeSh <= '0;
    end else if (strb.clearCode) begin
      codeSh <= '0;
    end else if (strb.shiftCode) begin
      codeSh <= {codeSh[CODE_STEPS-2:0], addrNib[CODE_LINE]};
    end
  end

  always_ff @(posedge clk or negedge pwrOk) begin
    if (!pwrOk) begin
      bankOn  <= 1'b0;
      bankNum <= '0;
    end else if (strb.commit) begin
      bankOn  <= codeSh[CODE_STEPS-1];
      bankNum <= codeSh[CODE_STEPS-1] ? codeSh[BANK_W-1:0] : '0;
    end
  end

  assign bankSel = bankNum;
  assign ceOutN  = bankOn ? ceInN : 1'b1;

endmodule

// File: rtl/bank_unlock.sv
module bank_unlock
  import bank_unlock_pkg::*;
#(
  parameter int          NUM_STEPS  = 16,
  parameter int          CODE_STEPS = 5,
  parameter logic [63:0] PATTERN    = DEFAULT_PATTERN,
  localparam int STEP_W = $clog2(NUM_STEPS),
  localparam int BANK_W = CODE_STEPS - 1
) (
  input  logic              clk,
  input  logic              pwrOk,
  input  logic              ceInN,
  input  logic              wrN,
  input  logic              addrW,
  input  logic              addrX,
  input  logic              addrY,
  input  logic              addrZ,
  output logic [BANK_W-1:0] bankSel,
  output logic              ceOutN
);

  logic              fallStb;
  logic              riseStb;
  logic              stepMatch;
  logic              allOnes;
  logic [STEP_W-1:0] stepIdx;
  ctrlStrb_t         strb;
  logic [NIB_W-1:0]  addrNib;

  assign addrNib = {addrW, addrX, addrY, addrZ};

  bank_unlock_edge u_edge (
    .clk     (clk),
    .pwrOk   (pwrOk),
    .ceInN   (ceInN),
    .fallStb (fallStb),
    .riseStb (riseStb)
  );

  bank_unlock_ctrl #(
    .NUM_STEPS  (NUM_STEPS),
    .CODE_STEPS (CODE_STEPS)
  ) u_ctl (
    .clk       (clk),
    .pwrOk     (pwrOk),
    .fallStb   (fallStb),
    .riseStb   (riseStb),
    .wrN       (wrN),
    .stepMatch (stepMatch),
    .allOnes   (allOnes),
    .stepIdx   (stepIdx),
    .strb      (strb)
  );

  bank_unlock_dp #(
    .NUM_STEPS  (NUM_STEPS),
    .CODE_STEPS (CODE_STEPS),
    .PATTERN    (PATTERN)
  ) u_dp (
    .clk       (clk),
    .pwrOk     (pwrOk),
    .addrNib   (addrNib),
    .ceInN     (ceInN),
    .stepIdx   (stepIdx),
    .strb      (strb),
    .stepMatch (stepMatch),
    .allOnes   (allOnes),
    .bankSel   (bankSel),
    .ceOutN    (ceOutN)
  );

endmodule

// File: rtl/bank_unlock_chk.sv
module bank_unlock_chk #(
  parameter int STEP_W = 4,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              pwrOk,
  input logic              ceInN,
  input logic              wrN,
  input logic [3:0]        addr,
  input logic [BANK_W-1:0] bankSel,
  input logic              ceOutN,
  input logic [STEP_W-1:0] stepIdx
);

  // R1: reset state seen at every clock while power is not good
  always_ff @(posedge clk) begin
    if (!pwrOk) begin
      a_reset_state_r1: assert (bankSel == '0 && ceOutN && stepIdx == '0)
        else $error("reset state violated");
    end
  end

  // R11: an inactive input chip enable is never passed on as active
  p_idle_ce_r11: assert property (@(posedge clk) disable iff (!pwrOk)
    ceInN |-> ceOutN);

  // R2: entry step moves only on a falling chip enable
  p_step_hold_r2: assert property (@(posedge clk) disable iff (!pwrOk)
    ($past(pwrOk) && !$fell(ceInN)) |=> $stable(stepIdx));

  // R7: a write cycle returns entry to step 0
  p_write_clear_r7: assert property (@(posedge clk) disable iff (!pwrOk)
    ($fell(ceInN) && !wrN) |=> (stepIdx == '0));

  // R5: an all-ones read returns entry to step 0
  p_restart_r5: assert property (@(posedge clk) disable iff (!pwrOk)
    ($fell(ceInN) && wrN && (addr == 4'hF)) |=> (stepIdx == '0));

  // R12: bank number moves only right after a rising chip enable
  p_bank_hold_r12: assert property (@(posedge clk) disable iff (!pwrOk)
    ($past(pwrOk) && !$rose(ceInN)) |=> $stable(bankSel));

endmodule

bind bank_unlock bank_unlock_chk #(
  .STEP_W (STEP_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk     (clk),
  .pwrOk   (pwrOk),
  .ceInN   (ceInN),
  .wrN     (wrN),
  .addr    ({addrW, addrX, addrY, addrZ}),
  .bankSel (bankSel),
  .ceOutN  (ceOutN),
  .stepIdx (stepIdx)
);

// File: tb/bank_unlock_tb.sv
module bank_unlock_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       pwrOk = 1'b0;
  logic       ceInN = 1'b1;
  logic       wrN = 1'b1;
  logic       addrW = 1'b0, addrX = 1'b0, addrY = 1'b0, addrZ = 1'b0;
  logic [3:0] bankSel;
  logic       ceOutN;

  int errCnt = 0;
  int chkCnt = 0;
  string curReq = "R1";

  // Pattern from the requirements (R3, R4), step order
  int pat[16] = '{5, 10, 3, 12, 6, 9, 1, 8, 4, 2, 14, 2, 5, 1, 6, 4};

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_unlock u_dut (
    .clk(clk), .pwrOk(pwrOk), .ceInN(ceInN), .wrN(wrN),
    .addrW(addrW), .addrX(addrX), .addrY(addrY), .addrZ(addrZ),
    .bankSel(bankSel), .ceOutN(ceOutN)
  );

  task automatic check(string req, int act, int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mStep = 0;
  bit  mArmed = 0;
  bit  mOn = 0;
  int  mNum = 0;
  bit  mPrevCe = 1;
  bit  mCode[$];

  function automatic bit stepOk(int s, bit [3:0] n);
    if (s >= 11) return n[2:0] == pat[s][2:0];
    return n == pat[s][3:0];
  endfunction

  always @(posedge clk) begin
    bit [3:0] nib;
    nib = {addrW, addrX, addrY, addrZ};
    if (!pwrOk) begin
      mStep = 0; mArmed = 0; mOn = 0; mNum = 0; mPrevCe = 1; mCode.delete();
    end else begin
      if (mPrevCe && !ceInN) begin
        mArmed = 0;
        if (!wrN || nib == 4'hF) begin
          mStep = 0; mCode.delete();
        end else if (stepOk(mStep, nib)) begin
          if (mStep >= 11) mCode.push_back(addrW);
          if (mStep == 15) begin mArmed = 1; mStep = 0; end
          else mStep++;
        end else begin
          mStep = 0; mCode.delete();
        end
      end else if (!mPrevCe && ceInN && mArmed) begin
        mArmed = 0;
        if (mCode.size() == 5 && mCode[0]) begin
          mOn = 1;
          mNum = mCode[1]*8 + mCode[2]*4 + mCode[3]*2 + mCode[4];
        end else begin
          mOn = 0; mNum = 0;
        end
        mCode.delete();
      end
      mPrevCe = ceInN;
    end
  end

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    check({curReq, " bankSel"}, int'(bankSel), mOn ? mNum : 0);
    check({curReq, " ceOutN"}, int'(ceOutN), mOn ? int'(ceInN) : 1);
  end

  // ---------------- stimulus helpers ----------------
  task automatic readCycle(bit [3:0] nib, bit wr, int lowClks);
    @(negedge clk);
    {addrW, addrX, addrY, addrZ} = nib;
    wrN = wr;
    ceInN = 1'b0;
    repeat (lowClks) @(negedge clk);
    ceInN = 1'b1;
    wrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendSteps(bit en, bit [3:0] num, int first, int last);
    bit [4:0] code;
    code = {en, num};
    for (int s = first; s <= last; s++) begin
      bit [3:0] nib;
      nib = pat[s][3:0];
      if (s >= 11) nib[3] = code[4 - (s - 11)];
      readCycle(nib, 1'b1, 1);
    end
  endtask

  // ---------------- scenarios ----------------
  initial begin
    repeat (4) @(negedge clk);
    curReq = "R1";
    check("R1 reset bankSel", int'(bankSel), 0);
    check("R1 reset ceOutN", int'(ceOutN), 1);
    pwrOk = 1'b1;
    repeat (2) @(negedge clk);

    // R8 / R10: bank 9, commit only after final rising edge
    curReq = "R10";
    sendSteps(1'b1, 4'd9, 0, 14);
    @(negedge clk);
    {addrW, addrX, addrY, addrZ} = 4'b1100;  // step 15, code bit 1
    ceInN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 no change before rise", int'(bankSel), 0);
    ceInN = 1'b1;
    @(negedge clk);
    check("R10 bank 9 selected", int'(bankSel), 9);

    // R11: output follows input while a bank is on
    curReq = "R11";
    @(negedge clk);
    {addrW, addrX, addrY, addrZ} = 4'b0000;
    ceInN = 1'b0;
    @(negedge clk);
    check("R11 ceOutN low", int'(ceOutN), 0);
    ceInN = 1'b1;
    @(negedge clk);
    check("R11 ceOutN high", int'(ceOutN), 1);

    // R6: mismatch aborts, tail alone does not unlock
    curReq = "R6";
    sendSteps(1'b1, 4'd3, 0, 6);
    readCycle(4'h0, 1'b1, 1);
    sendSteps(1'b1, 4'd3, 7, 15);
    check("R6 bank kept after mismatch", int'(bankSel), 9);
    sendSteps(1'b1, 4'd3, 0, 15);
    check("R6 fresh sequence selects 3", int'(bankSel), 3);

    // R7: write in the middle aborts
    curReq = "R7";
    sendSteps(1'b1, 4'd11, 0, 8);
    readCycle(pat[9][3:0], 1'b0, 1);
    sendSteps(1'b1, 4'd11, 9, 15);
    check("R7 bank kept after write", int'(bankSel), 3);

    // R5: all-ones restarts entry
    curReq = "R5";
    sendSteps(1'b1, 4'd7, 0, 5);
    readCycle(4'hF, 1'b1, 1);
    sendSteps(1'b1, 4'd7, 6, 15);
    check("R5 restart drops partial entry", int'(bankSel), 3);
    sendSteps(1'b1, 4'd6, 0, 3);
    readCycle(4'hF, 1'b1, 1);
    sendSteps(1'b1, 4'd6, 0, 15);
    check("R5 restart then full sequence", int'(bankSel), 6);

    // R3: addrW compared in step 10
    curReq = "R3";
    sendSteps(1'b1, 4'd1, 0, 9);
    readCycle(pat[10][3:0] ^ 4'h8, 1'b1, 1);
    sendSteps(1'b1, 4'd1, 11, 15);
    check("R3 addrW wrong at step 10", int'(bankSel), 6);

    // R4: addrW free in code steps (bank 15 flips every code bit)
    curReq = "R4";
    sendSteps(1'b1, 4'd15, 0, 15);
    check("R4 code bits ignored in compare", int'(bankSel), 15);

    // R2: a long read is one sample; writes do not advance
    curReq = "R2";
    for (int s = 0; s <= 15; s++) begin
      bit [3:0] nib;
      bit [4:0] code;
      code = 5'b1_1101;
      nib = pat[s][3:0];
      if (s >= 11) nib[3] = code[4 - (s - 11)];
      readCycle(nib, 1'b1, (s == 3) ? 5 : 1);
    end
    check("R2 held read counted once", int'(bankSel), 13);

    // R9: banks off
    curReq = "R9";
    sendSteps(1'b0, 4'b1010, 0, 15);
    check("R9 banks off bankSel", int'(bankSel), 0);
    @(negedge clk);
    ceInN = 1'b0;
    @(negedge clk);
    check("R9 ceOutN held high", int'(ceOutN), 1);
    ceInN = 1'b1;
    @(negedge clk);

    // R12: selection holds over arbitrary traffic
    curReq = "R12";
    sendSteps(1'b1, 4'd12, 0, 15);
    for (int i = 0; i < 24; i++) begin
      readCycle(4'($urandom_range(0, 14)), 1'($urandom_range(0, 1)), 1 + (i % 3));
    end
    check("R12 bank held", int'(bankSel), 12);

    // R1: power-fail reset again
    curReq = "R1";
    @(negedge clk);
    pwrOk = 1'b0;
    @(negedge clk);
    check("R1 reset clears bank", int'(bankSel), 0);
    check("R1 reset ceOutN", int'(ceOutN), 1);
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule